// File: doc/BRIEF.md
# Bipolar Stepper Phase Sequencer

This block sequences the two full bridges of a two-phase bipolar stepper motor. It keeps a position index on a half-step grid of eight phases, A through H. Each rising edge of a step input, sampled on the system clock, moves the index one position. The direction input, the step-size select and the current index choose the next position. The index is decoded into a high-side enable and a low-side enable for each of the four coil terminals. A terminal with both enables off floats.

In half-step mode the odd phases energize one coil only. The idle-coil control then chooses whether the unused coil floats or has both of its terminals pulled to the supply. A set input forces the home phase (A) and floats every terminal while it is held. It also blocks every control input. An active-low flag marks the home phase. All inputs are assumed to be synchronous to `clk` already. Control and status pins are plain levels, and no data stream passes through the block.

Top module: `stepper_seq`

## Requirements
- R1: The position changes only on a clock where the step input is high and was low on the previous clock, and then by exactly one move. A held-high step input, a falling step input, and changes to direction, mode or idle control without a step edge leave the outputs unchanged.
- R2: With full-step mode (half_step=0) and dir_ccw=0, even positions follow 0,2,4,6,0. The coil polarities (coil 1, coil 2) are (+,+), (−,+), (−,−), (+,−). Coil 1 is terminal bits 0/1 and coil 2 is terminal bits 2/3. "+" means the lower bit has its high side on and the upper bit has its low side on. "−" is the reverse.
- R3: In half-step mode (half_step=1) each step moves the position by one through all eight phases. An odd phase drives only the coil shared by its two even neighbours: phase 1 gives coil 2 +, phase 3 gives coil 1 −, phase 5 gives coil 2 −, and phase 7 gives coil 1 +.
- R4: dir_ccw=1 visits the phases in the reverse order.
- R5: In half-step mode with idle_clamp=0, both enables of both terminals of the idle coil are off.
- R6: In half-step mode with idle_clamp=1, both idle-coil terminals have the high side on and the low side off. In full-step mode idle_clamp has no effect, and an idle coil floats.
- R7: In full-step mode, a step taken from an odd position goes to the adjacent even position in the selected direction. Later steps move by two.
- R8: phase_a_n is low exactly when the outputs show the phase-A pattern (hi_en=0101, lo_en=1010) or set_hold is high.
- R9: While set_hold is high, all eight enables are 0 and phase_a_n is 0, starting in the same cycle. Steps, direction and mode inputs are ignored, and the position is forced to A.
- R10: When set_hold falls, the phase-A pattern appears in that same cycle, and the next step edge advances normally from A.
- R11: The high-side and low-side enables of any one terminal are never on together.
- R12: After reset the outputs show the phase-A pattern with phase_a_n low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_in | input | 1 | Step request; its rising edge advances the position |
| dir_ccw | input | 1 | 0 = forward order, 1 = reverse order |
| half_step | input | 1 | 0 = full steps, 1 = half steps |
| idle_clamp | input | 1 | Half-step idle coil: 0 = float, 1 = both high sides on |
| set_hold | input | 1 | Active-high set: home position, all terminals floating |
| hi_en | output | 4 | High-side enable per terminal (bit 0 = terminal 1) |
| lo_en | output | 4 | Low-side enable per terminal |
| phase_a_n | output | 1 | Low while in the home phase or in set |

## Verification
The hardest state to reach is a switch to full-step mode while the index is on an odd half-step phase. The bench first leaves the sequencer on phase 5 or phase 3 with half steps, then issues a full-step edge in each direction and checks that the move lands on the adjacent even phase. From that same odd phase it also changes the mode with no step edge. The idle coil must then float even though idle_clamp is high. Set is asserted away from home and combined with step pulses and direction changes, so the bench can show that the inputs are blocked and that home appears as soon as set is released.

// File: rtl/stp_pkg.sv
package stp_pkg;
  localparam int COILS       = 2;
  localparam int TERMS       = 2 * COILS;
  localparam int HALF_PHASES = 8;
  localparam int IDX_W       = $clog2(HALF_PHASES);

  typedef enum logic [1:0] {
    COIL_IDLE = 2'd0,
    COIL_POS  = 2'd1,
    COIL_NEG  = 2'd2
  } coil_drive_e;
endpackage

// File: rtl/stp_edge.sv
module stp_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o
);
  logic prev_q;

  // Reset high so a step input already high at reset is not taken as a step.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;

  p_single_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/stp_position.sv
module stp_position
  import stp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  input  logic             rev_i,
  input  logic             half_i,
  input  logic             home_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] idx_q, stride, idx_nxt;

  always_comb begin
    // Full steps from an odd phase move one, to realign onto the even grid.
    stride = (half_i || idx_q[0]) ? IDX_W'(1) : IDX_W'(2);
    idx_nxt = rev_i ? (idx_q - stride) : (idx_q + stride);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (home_i) idx_q <= '0;
    else if (adv_i)  idx_q <= idx_nxt;
  end

  assign idx_o = idx_q;

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !home_i) |=> $stable(idx_q));
  p_half_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && half_i && !home_i) |=>
      ((idx_q == $past(idx_q) + 1'b1) || (idx_q == $past(idx_q) - 1'b1)));
  p_full_even_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !half_i && !home_i) |=> !idx_q[0]);
  p_home_r9: assert property (@(posedge clk) disable iff (!rst_n)
    home_i |=> (idx_q == '0));
endmodule

// File: rtl/stp_coil_map.sv
module stp_coil_map
  import stp_pkg::*;
(
  input  logic [IDX_W-1:0]        idx_i,
  output coil_drive_e [COILS-1:0] drv_o
);
  // Entry 0 is coil 1 and entry 1 is coil 2. Even phases drive both coils.
  always_comb begin
    unique case (idx_i)
      3'd0: drv_o = {COIL_POS,  COIL_POS };
      3'd1: drv_o = {COIL_POS,  COIL_IDLE};
      3'd2: drv_o = {COIL_POS,  COIL_NEG };
      3'd3: drv_o = {COIL_IDLE, COIL_NEG };
      3'd4: drv_o = {COIL_NEG,  COIL_NEG };
      3'd5: drv_o = {COIL_NEG,  COIL_IDLE};
      3'd6: drv_o = {COIL_NEG,  COIL_POS };
      default: drv_o = {COIL_IDLE, COIL_POS};
    endcase
  end
endmodule

// File: rtl/stp_bridge_drv.sv
module stp_bridge_drv
  import stp_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  coil_drive_e [COILS-1:0] drv_i,
  input  logic                    clamp_i,
  input  logic                    off_i,
  output logic [TERMS-1:0]        hi_o,
  output logic [TERMS-1:0]        lo_o
);
  for (genvar c = 0; c < COILS; c++) begin : g_coil
    logic [1:0] hi_pair, lo_pair;
    always_comb begin
      hi_pair = 2'b00;
      lo_pair = 2'b00;
      if (!off_i) begin
        unique case (drv_i[c])
          COIL_POS: begin hi_pair = 2'b01; lo_pair = 2'b10; end
          COIL_NEG: begin hi_pair = 2'b10; lo_pair = 2'b01; end
          default:  hi_pair = clamp_i ? 2'b11 : 2'b00;
        endcase
      end
    end
    assign hi_o[2*c +: 2] = hi_pair;
    assign lo_o[2*c +: 2] = lo_pair;
  end

  p_no_shoot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_o & lo_o) == '0);
endmodule

// File: rtl/stepper_seq.sv
module stepper_seq
  import stp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_in,
  input  logic             dir_ccw,
  input  logic             half_step,
  input  logic             idle_clamp,
  input  logic             set_hold,
  output logic [TERMS-1:0] hi_en,
  output logic [TERMS-1:0] lo_en,
  output logic             phase_a_n
);
  localparam logic [TERMS-1:0] HOME_HI = {COILS{2'b01}};
  localparam logic [TERMS-1:0] HOME_LO = {COILS{2'b10}};

  logic                    step_rise;
  logic [IDX_W-1:0]        idx;
  coil_drive_e [COILS-1:0] drv;

  stp_edge u_edge (
    .clk(clk), .rst_n(rst_n), .level_i(step_in), .rise_o(step_rise)
  );

  stp_position u_pos (
    .clk(clk), .rst_n(rst_n), .adv_i(step_rise), .rev_i(dir_ccw),
    .half_i(half_step), .home_i(set_hold), .idx_o(idx)
  );

  stp_coil_map u_map (.idx_i(idx), .drv_o(drv));

  stp_bridge_drv u_drv (
    .clk(clk), .rst_n(rst_n), .drv_i(drv),
    .clamp_i(idle_clamp & half_step), .off_i(set_hold),
    .hi_o(hi_en), .lo_o(lo_en)
  );

  assign phase_a_n = ~(set_hold | (idx == '0));

  p_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase_a_n && !set_hold) |-> (hi_en == HOME_HI && lo_en == HOME_LO));
  p_flag_back_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_en == HOME_HI && lo_en == HOME_LO) |-> !phase_a_n);
  p_set_float_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set_hold |-> (hi_en == '0 && lo_en == '0 && !phase_a_n));
endmodule

// File: tb/stepper_seq_bench.sv
module stepper_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_in = 1'b0, dir_ccw = 1'b0, half_step = 1'b0;
  logic idle_clamp = 1'b0, set_hold = 1'b0;
  logic [3:0] hi_en, lo_en;
  logic phase_a_n;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  stepper_seq u_stepper_seq (
    .clk(clk), .rst_n(rst_n), .step_in(step_in), .dir_ccw(dir_ccw),
    .half_step(half_step), .idle_clamp(idle_clamp), .set_hold(set_hold),
    .hi_en(hi_en), .lo_en(lo_en), .phase_a_n(phase_a_n)
  );

  // {ccw, half, clamp, hi[3:0], lo[3:0], flag_n}: expected after one step
  localparam logic [11:0] VEC [21] = '{
    12'b0_0_0_0110_1001_1, // R2 0->2
    12'b0_0_0_1010_0101_1, // R2 ->4
    12'b0_0_0_1001_0110_1, // R2 ->6
    12'b0_0_0_0101_1010_0, // R2 R8 ->0
    12'b1_0_0_1001_0110_1, // R4 ->6
    12'b0_1_0_0001_0010_1, // R3 R5 ->7
    12'b0_1_1_0101_1010_0, // R3 ->0
    12'b0_1_1_0111_1000_1, // R6 ->1
    12'b0_1_0_0110_1001_1, // R3 ->2
    12'b0_1_1_1110_0001_1, // R6 ->3
    12'b0_1_0_1010_0101_1, // R3 ->4
    12'b0_1_1_1011_0100_1, // R6 ->5
    12'b0_0_1_1001_0110_1, // R7 5->6
    12'b0_0_0_0101_1010_0, // R2 ->0
    12'b1_1_0_0001_0010_1, // R4 ->7
    12'b1_1_0_1001_0110_1, // R4 ->6
    12'b1_1_1_1011_0100_1, // R6 ->5
    12'b1_0_0_1010_0101_1, // R7 5->4
    12'b1_0_0_0110_1001_1, // R4 ->2
    12'b0_1_1_1110_0001_1, // R6 ->3
    12'b1_0_0_0110_1001_1  // R7 3->2
  };

  task automatic check(string req, logic [3:0] eh, logic [3:0] el, logic ef);
    total++;
    if (hi_en !== eh || lo_en !== el || phase_a_n !== ef) begin
      bad++;
      $display("FAIL %s: hi=%b lo=%b flag=%b expected hi=%b lo=%b flag=%b",
               req, hi_en, lo_en, phase_a_n, eh, el, ef);
    end
  endtask

  task automatic do_step(logic ccw, logic half, logic clamp);
    @(negedge clk);
    dir_ccw = ccw; half_step = half; idle_clamp = clamp; step_in = 1'b1;
    @(negedge clk);
    step_in = 1'b0;
    @(negedge clk);
    #2;
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog: run did not finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2 check("R12 reset", 4'b0101, 4'b1010, 1'b0);

    for (int i = 0; i < 21; i++) begin
      do_step(VEC[i][11], VEC[i][10], VEC[i][9]);
      check($sformatf("R1-table step %0d", i), VEC[i][8:5], VEC[i][4:1], VEC[i][0]);
    end
    // now at phase 2; R1: held-high step gives only one move
    @(negedge clk); dir_ccw = 0; half_step = 0; idle_clamp = 0; step_in = 1;
    repeat (4) @(negedge clk);
    #2 check("R1 held high", 4'b1010, 4'b0101, 1'b1);
    step_in = 0;
    repeat (2) @(negedge clk);
    #2 check("R1 falling edge", 4'b1010, 4'b0101, 1'b1);
    half_step = 1; dir_ccw = 1; idle_clamp = 1;
    repeat (2) @(negedge clk);
    #2 check("R1 controls without edge", 4'b1010, 4'b0101, 1'b1);
    // R6: idle control no effect in full mode while on odd phase 5
    do_step(0, 1, 0);
    check("R5 float at 5", 4'b1000, 4'b0100, 1'b1);
    half_step = 0; idle_clamp = 1;
    @(negedge clk); #2 check("R6 clamp ignored in full mode", 4'b1000, 4'b0100, 1'b1);
    // R9: set away from home
    set_hold = 1;
    #2 check("R9 set floats", 4'b0000, 4'b0000, 1'b0);
    step_in = 1; dir_ccw = 1; half_step = 1;
    @(negedge clk); step_in = 0;
    repeat (2) @(negedge clk);
    #2 check("R9 inputs ignored", 4'b0000, 4'b0000, 1'b0);
    dir_ccw = 0; half_step = 0; idle_clamp = 0;
    set_hold = 0;
    #2 check("R10 home on release", 4'b0101, 4'b1010, 1'b0);
    do_step(0, 0, 0);
    check("R10 first step after set", 4'b0110, 4'b1001, 1'b1);
    do_step(1, 0, 0);
    check("R4 R8 back home", 4'b0101, 4'b1010, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule